// File: doc/BRIEF.md
# Display Gamma Correction Table with Streaming Loader

This block is the gamma correction stage of a multi-output display compositor. Each output channel owns its own correction curve. A curve is three 256-entry tables of 8-bit values, one for each colour component. A pixel stream tagged with a channel index enters the block. Each component of the RGB888 pixel is replaced by the table entry it selects. The corrected pixel comes out two cycles later. A per-channel enable can switch the curve off. The pixel then passes through unchanged, which matches an identity curve.

The tables live in one flat storage array. Software loads it through two write strobes. The first loads a pointer together with a step flag. The second stores one byte at the pointer. A small loader state machine tracks the pointer. It has three states:
- `LD_HOLD`: the step flag is clear, so the pointer stays put.
- `LD_STEP`: the step flag is set, so the pointer advances after each store.
- `LD_PAST`: the pointer lies beyond the last entry, so stores are discarded.

Its transitions are:
- A pointer load enters any of the three states, depending on the value and the flag.
- A store in `LD_STEP` at the last entry moves to `LD_PAST`.
- A store in `LD_HOLD` or `LD_PAST` stays in the same state.

Top module: `gamma_lut_top`

## Requirements
- R1: The entry for channel c, colour k (0 red, 1 green, 2 blue) and input level v sits at address c*768 + k*256 + v. Red is pixel bits [23:16], green is bits [15:8] and blue is bits [7:0], on both the input and the output.
- R2: When the pixel's channel has its enable bit set in `gamma_en`, each output component equals the stored entry that the input component selects.
- R3: A pointer load with `cfg_autoinc` set enters `LD_STEP`. Each store in that state writes the byte at the pointer and then advances the pointer by one.
- R4: A pointer load with `cfg_autoinc` clear enters `LD_HOLD`. Repeated stores in that state overwrite the same entry.
- R5: When the channel's enable bit is clear, or when the channel index is 3 or higher, the output pixel equals the input pixel.
- R6: `out_valid` follows `pix_valid` exactly two cycles later, with the corrected or bypassed pixel aligned to it. The latency is the same in both modes.
- R7: Stores at pointer values of 2304 and above change nothing (`LD_PAST`). Stepping stops at 2304 after the entry at 2303 is written.
- R8: A pointer load and a store in the same cycle load the pointer and drop the store.
- R9: A lookup and a store that hit the same entry in the same cycle return the entry's old value. Later lookups see the new value.
- R10: After reset, `out_valid` is low and the loader is in `LD_HOLD` with the pointer at 0.
- R11: The enable bit is taken in the cycle the pixel enters the block. A change of `gamma_en` while the pixel is in flight has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr_we | input | 1 | Load the pointer and the step flag |
| cfg_addr | input | 12 | Pointer value to load |
| cfg_autoinc | input | 1 | Step flag loaded with the pointer |
| cfg_data_we | input | 1 | Store one byte at the pointer |
| cfg_data | input | 8 | Byte to store |
| gamma_en | input | 3 | Per-channel curve enable |
| pix_valid | input | 1 | Input pixel valid |
| pix_chan | input | 2 | Channel index of the input pixel |
| pix_rgb | input | 24 | Input pixel, RGB888 |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Corrected or bypassed pixel |

## Verification
The bench builds the block with its defaults: three channels and 8-bit components. A full 2304-entry load therefore fits in a few thousand cycles. This lets the bench reach the end-of-table stop and the discarded stores past it. With three channels the 2-bit channel index can also take the unused code 3, which exercises the bypass for channels that do not exist. The behavioural model compares the output on every clock. This covers read-before-write collisions and enable changes made while a pixel is in flight.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

    localparam int NUM_COLOURS = 3;

    typedef enum logic [1:0] {
        LD_HOLD = 2'd0,
        LD_STEP = 2'd1,
        LD_PAST = 2'd2
    } ld_state_e;

endpackage

// File: rtl/gamma_lut_loader.sv
module gamma_lut_loader
    import gamma_lut_pkg::*;
#(
    parameter int DEPTH  = 2304,
    parameter int ADDR_W = 12,
    parameter int PIX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_addr_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_autoinc,
    input  logic              cfg_data_we,
    input  logic [PIX_W-1:0]  cfg_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_data,
    output logic [ADDR_W-1:0] ptr_q,
    output ld_state_e         state_q
);

    localparam logic [ADDR_W-1:0] END_ADDR  = ADDR_W'(DEPTH);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    ld_state_e         state_d;
    logic [ADDR_W-1:0] ptr_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_HOLD;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (cfg_addr_we) begin
            ptr_d = cfg_addr;
            if (cfg_addr >= END_ADDR) begin
                state_d = LD_PAST;
            end else if (cfg_autoinc) begin
                state_d = LD_STEP;
            end else begin
                state_d = LD_HOLD;
            end
        end else if (cfg_data_we) begin
            unique case (state_q)
                LD_HOLD: begin
                    state_d = LD_HOLD;
                end
                LD_STEP: begin
                    ptr_d = ptr_q + 1'b1;
                    if (ptr_q == LAST_ADDR) begin
                        state_d = LD_PAST;
                    end
                end
                LD_PAST: begin
                    state_d = LD_PAST;
                end
                default: begin
                    state_d = LD_HOLD;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_we   = cfg_data_we && !cfg_addr_we && (state_q != LD_PAST);
        mem_addr = ptr_q;
        mem_data = cfg_data;
    end

endmodule

// File: rtl/gamma_lut_store.sv
module gamma_lut_store
    import gamma_lut_pkg::*;
#(
    parameter int DEPTH  = 2304,
    parameter int ADDR_W = 12,
    parameter int PIX_W  = 8
) (
    input  logic                                clk,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [PIX_W-1:0]                    wr_data,
    input  logic [NUM_COLOURS-1:0][ADDR_W-1:0]  rd_addr,
    output logic [NUM_COLOURS-1:0][PIX_W-1:0]   rd_q
);

    logic [PIX_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // one registered read port per colour; reads see the pre-write contents
    for (genvar k = 0; k < NUM_COLOURS; k++) begin : g_port
        logic [PIX_W-1:0] q;
        always_ff @(posedge clk) begin
            q <= mem[rd_addr[k]];
        end
        assign rd_q[k] = q;
    end

endmodule

// File: rtl/gamma_lut_pixpipe.sv
module gamma_lut_pixpipe
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int PIX_W  = 8,
    parameter int CH_W   = 2,
    parameter int ADDR_W = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                pix_valid,
    input  logic [CH_W-1:0]                     pix_chan,
    input  logic [NUM_COLOURS*PIX_W-1:0]        pix_rgb,
    input  logic [NUM_CH-1:0]                   gamma_en,
    input  logic [NUM_COLOURS-1:0][PIX_W-1:0]   rd_q,
    output logic [NUM_COLOURS-1:0][ADDR_W-1:0]  rd_addr,
    output logic                                out_valid,
    output logic [NUM_COLOURS*PIX_W-1:0]        out_rgb
);

    localparam int RGB_W   = NUM_COLOURS * PIX_W;
    localparam int LEVELS  = 1 << PIX_W;
    localparam int CH_SPAN = NUM_COLOURS * LEVELS;

    logic             en_sel;
    logic             s1_valid;
    logic             s1_en;
    logic [CH_W-1:0]  s1_chan;
    logic [RGB_W-1:0] s1_rgb;
    logic             o_valid;
    logic             o_en;
    logic [RGB_W-1:0] o_rgb;

    always_comb begin
        en_sel = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (pix_chan == CH_W'(i)) begin
                en_sel = gamma_en[i];
            end
        end
    end

    // stage 1: capture pixel and its enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_en    <= 1'b0;
            s1_chan  <= '0;
            s1_rgb   <= '0;
        end else begin
            s1_valid <= pix_valid;
            s1_en    <= en_sel;
            s1_chan  <= pix_chan;
            s1_rgb   <= pix_rgb;
        end
    end

    for (genvar k = 0; k < NUM_COLOURS; k++) begin : g_addr
        logic [PIX_W-1:0] level;
        assign level = s1_rgb[(NUM_COLOURS-1-k)*PIX_W +: PIX_W];
        always_comb begin
            if (s1_en) begin
                rd_addr[k] = ADDR_W'(s1_chan) * ADDR_W'(CH_SPAN)
                           + ADDR_W'(k * LEVELS) + ADDR_W'(level);
            end else begin
                rd_addr[k] = '0;
            end
        end
    end

    // stage 2: align bypass data with the table read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_en    <= 1'b0;
            o_rgb   <= '0;
        end else begin
            o_valid <= s1_valid;
            o_en    <= s1_en;
            o_rgb   <= s1_rgb;
        end
    end

    for (genvar k = 0; k < NUM_COLOURS; k++) begin : g_out
        localparam int LSB = (NUM_COLOURS-1-k) * PIX_W;
        assign out_rgb[LSB +: PIX_W] = o_en ? rd_q[k] : o_rgb[LSB +: PIX_W];
    end

    assign out_valid = o_valid;

endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int PIX_W  = 8,
    localparam int LEVELS = 1 << PIX_W,
    localparam int DEPTH  = NUM_CH * NUM_COLOURS * LEVELS,
    localparam int ADDR_W = $clog2(DEPTH + 1),
    localparam int CH_W   = $clog2(NUM_CH + 1),
    localparam int RGB_W  = NUM_COLOURS * PIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_addr_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_autoinc,
    input  logic              cfg_data_we,
    input  logic [PIX_W-1:0]  cfg_data,
    input  logic [NUM_CH-1:0] gamma_en,
    input  logic              pix_valid,
    input  logic [CH_W-1:0]   pix_chan,
    input  logic [RGB_W-1:0]  pix_rgb,
    output logic              out_valid,
    output logic [RGB_W-1:0]  out_rgb
);

    logic                               mem_we;
    logic [ADDR_W-1:0]                  mem_addr;
    logic [PIX_W-1:0]                   mem_data;
    logic [ADDR_W-1:0]                  ld_ptr;
    ld_state_e                          ld_state;
    logic [NUM_COLOURS-1:0][ADDR_W-1:0] rd_addr;
    logic [NUM_COLOURS-1:0][PIX_W-1:0]  rd_q;

    gamma_lut_loader #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .PIX_W (PIX_W)
    ) i_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_addr_we(cfg_addr_we),
        .cfg_addr   (cfg_addr),
        .cfg_autoinc(cfg_autoinc),
        .cfg_data_we(cfg_data_we),
        .cfg_data   (cfg_data),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .ptr_q      (ld_ptr),
        .state_q    (ld_state)
    );

    gamma_lut_store #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .PIX_W (PIX_W)
    ) i_store (
        .clk    (clk),
        .wr_en  (mem_we),
        .wr_addr(mem_addr),
        .wr_data(mem_data),
        .rd_addr(rd_addr),
        .rd_q   (rd_q)
    );

    gamma_lut_pixpipe #(
        .NUM_CH(NUM_CH),
        .PIX_W (PIX_W),
        .CH_W  (CH_W),
        .ADDR_W(ADDR_W)
    ) i_pixpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_valid(pix_valid),
        .pix_chan (pix_chan),
        .pix_rgb  (pix_rgb),
        .gamma_en (gamma_en),
        .rd_q     (rd_q),
        .rd_addr  (rd_addr),
        .out_valid(out_valid),
        .out_rgb  (out_rgb)
    );

endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int PIX_W  = 8,
    localparam int LEVELS = 1 << PIX_W,
    localparam int DEPTH  = NUM_CH * NUM_COLOURS * LEVELS,
    localparam int ADDR_W = $clog2(DEPTH + 1),
    localparam int CH_W   = $clog2(NUM_CH + 1),
    localparam int RGB_W  = NUM_COLOURS * PIX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_addr_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_data_we,
    input logic [NUM_CH-1:0] gamma_en,
    input logic              pix_valid,
    input logic [CH_W-1:0]   pix_chan,
    input logic [RGB_W-1:0]  pix_rgb,
    input logic              out_valid,
    input logic [RGB_W-1:0]  out_rgb,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] ld_ptr,
    input ld_state_e         ld_state
);

    logic [1:0] age;
    logic       chan_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd2) begin
            age <= age + 1'b1;
        end
    end

    always_comb begin
        chan_on = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (pix_chan == CH_W'(i)) begin
                chan_on = gamma_en[i];
            end
        end
    end

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_data_we && !cfg_addr_we && ld_state == LD_STEP) |=> (ld_ptr == $past(ld_ptr) + 1'b1)); // R3

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_data_we && !cfg_addr_we && ld_state == LD_HOLD) |=> $stable(ld_ptr)); // R4

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr_we |=> (ld_ptr == $past(cfg_addr))); // R8

    AST_LOAD_DROPS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr_we |-> !mem_we); // R8

    AST_NO_STORE_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr < ADDR_W'(DEPTH))); // R7

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (out_valid == $past(pix_valid, 2))); // R6

    AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && out_valid && !$past(chan_on, 2)) |-> (out_rgb == $past(pix_rgb, 2))); // R5

endmodule

bind gamma_lut_top gamma_lut_chk #(
    .NUM_CH(NUM_CH),
    .PIX_W (PIX_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_addr_we(cfg_addr_we),
    .cfg_addr   (cfg_addr),
    .cfg_data_we(cfg_data_we),
    .gamma_en   (gamma_en),
    .pix_valid  (pix_valid),
    .pix_chan   (pix_chan),
    .pix_rgb    (pix_rgb),
    .out_valid  (out_valid),
    .out_rgb    (out_rgb),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .ld_ptr     (ld_ptr),
    .ld_state   (ld_state)
);

// File: tb/test_gamma_lut_top.sv
module test_gamma_lut_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 3;
    localparam int DEPTH = 2304;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_addr_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic        cfg_autoinc = 1'b0;
    logic        cfg_data_we = 1'b0;
    logic [7:0]  cfg_data = '0;
    logic [2:0]  gamma_en = '0;
    logic        pix_valid = 1'b0;
    logic [1:0]  pix_chan = '0;
    logic [23:0] pix_rgb = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_req = "R10";

    gamma_lut_top i_gamma_lut_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_addr_we(cfg_addr_we),
        .cfg_addr   (cfg_addr),
        .cfg_autoinc(cfg_autoinc),
        .cfg_data_we(cfg_data_we),
        .cfg_data   (cfg_data),
        .gamma_en   (gamma_en),
        .pix_valid  (pix_valid),
        .pix_chan   (pix_chan),
        .pix_rgb    (pix_rgb),
        .out_valid  (out_valid),
        .out_rgb    (out_rgb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int unsigned ref_mem [DEPTH];
    int          ref_ptr;
    bit          ref_step;
    bit          m1_v, m1_en;
    int          m1_chan;
    int unsigned m1_rgb;
    bit          m2_v;
    int unsigned m2_rgb;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_ptr = 0; ref_step = 0;
            m1_v = 0; m1_en = 0; m1_chan = 0; m1_rgb = 0;
            m2_v = 0; m2_rgb = 0;
        end else begin
            m2_v = m1_v;
            if (m1_en) begin
                int unsigned r, g, b;
                r = ref_mem[m1_chan*768 + 0*256 + ((m1_rgb >> 16) & 255)];
                g = ref_mem[m1_chan*768 + 1*256 + ((m1_rgb >> 8) & 255)];
                b = ref_mem[m1_chan*768 + 2*256 + (m1_rgb & 255)];
                m2_rgb = (r << 16) | (g << 8) | b;
            end else begin
                m2_rgb = m1_rgb;
            end
            if (cfg_addr_we) begin
                ref_ptr = int'(cfg_addr);
                ref_step = cfg_autoinc;
            end else if (cfg_data_we && ref_ptr < DEPTH) begin
                ref_mem[ref_ptr] = cfg_data;
                if (ref_step) ref_ptr++;
            end
            m1_v = pix_valid;
            m1_chan = int'(pix_chan);
            m1_en = (m1_chan < NCH) && gamma_en[pix_chan];
            m1_rgb = pix_rgb;
        end
    end

    task automatic check(input string req, input int unsigned act, input int unsigned exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %06h expected %06h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({"R6 valid alignment / ", cur_req}, out_valid, m2_v);
            if (m2_v) check(cur_req, out_rgb, m2_rgb);
        end
    end

    task automatic addr_wr(input int a, input bit inc);
        cfg_addr_we = 1; cfg_addr = 12'(a); cfg_autoinc = inc;
        @(negedge clk);
        cfg_addr_we = 0;
    endtask

    task automatic data_wr(input int v);
        cfg_data_we = 1; cfg_data = 8'(v);
        @(negedge clk);
        cfg_data_we = 0;
    endtask

    task automatic pix(input int ch, input int unsigned rgb);
        pix_valid = 1; pix_chan = 2'(ch); pix_rgb = 24'(rgb);
        @(negedge clk);
        pix_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 out_valid in reset", out_valid, 0);
        rst_n = 1;
        @(negedge clk);
        check("R10 out_valid after reset", out_valid, 0);

        cur_req = "R10/R4 pointer at 0 in hold after reset";
        data_wr(8'h11);
        data_wr(8'h22);
        gamma_en = 3'b111;
        pix(0, 24'h000000);
        idle(3);

        cur_req = "R3/R1 stepped full load";
        addr_wr(0, 1);
        cfg_data_we = 1;
        for (int a = 0; a < DEPTH; a++) begin
            cfg_data = 8'((a * 7 + 13 + a / 256) & 255);
            @(negedge clk);
        end
        cfg_data_we = 0;

        cur_req = "R7 stores past the end ignored";
        data_wr(8'hAA);
        data_wr(8'h55);
        pix(2, 24'h0000FF);
        pix(0, 24'h000000);
        addr_wr(3000, 1);
        data_wr(8'h99);
        addr_wr(2303, 1);
        data_wr(8'h42);
        data_wr(8'h43);
        pix(2, 24'h0000FF);
        idle(3);

        cur_req = "R2/R1 streamed lookups";
        for (int i = 0; i < 240; i++) begin
            pix_valid = (i % 7) != 3;
            pix_chan = 2'(i % 3);
            pix_rgb = 24'((i * 40503 + 977) & 24'hFFFFFF);
            @(negedge clk);
        end
        pix_valid = 0;
        idle(3);

        cur_req = "R5 bypass for disabled and absent channels";
        gamma_en = 3'b101;
        for (int i = 0; i < 40; i++) pix(i % 4, 24'((i * 9973 + 31) & 24'hFFFFFF));
        gamma_en = 3'b000;
        pix(0, 24'h123456);
        pix(2, 24'hABCDEF);
        idle(3);

        cur_req = "R11 enable taken with the pixel";
        gamma_en = 3'b010;
        pix_valid = 1; pix_chan = 2'd1; pix_rgb = 24'h10203F;
        @(negedge clk);
        gamma_en = 3'b000;
        pix_chan = 2'd0; pix_rgb = 24'h405060;
        @(negedge clk);
        gamma_en = 3'b111;
        pix_valid = 0;
        idle(3);

        cur_req = "R8 pointer load wins over store";
        cfg_addr_we = 1; cfg_addr = 12'd10; cfg_autoinc = 0;
        cfg_data_we = 1; cfg_data = 8'hEE;
        @(negedge clk);
        cfg_addr_we = 0; cfg_data_we = 0;
        pix(0, 24'h0A0000);
        pix(0, 24'h0B0000);
        data_wr(8'h77);
        pix(0, 24'h0A0000);
        idle(3);

        cur_req = "R4 hold mode overwrites";
        addr_wr(768 + 256 + 5, 0);
        data_wr(8'h01);
        data_wr(8'h02);
        data_wr(8'h03);
        pix(1, 24'h000500);
        pix(1, 24'h000600);
        idle(3);

        cur_req = "R9 lookup during store returns old value";
        addr_wr(256 + 64, 0);
        pix_valid = 1; pix_chan = 2'd0; pix_rgb = 24'h004000;
        @(negedge clk);
        pix_valid = 0;
        data_wr(8'h5A);
        pix(0, 24'h004000);
        idle(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule